// File: doc/BRIEF.md
# Activity-Reloadable Idle Timers

This block holds two programmable countdown timers that detect idle periods. Software picks a time base for each timer and writes an initial count. It then sets the timer's start bit. The timer loads the count and steps it down by one on every tick of the selected time base.

When a timer steps from one to zero, it sets a sticky timeout flag. If the system-management enable for that timer is set, the flag also drives an interrupt request. A timer with auto-reload set loads its initial count again at that point and keeps running.

Each timer can also be restarted by activity pulses, so a timeout means that a chosen group of devices has been quiet for the whole period. Timer 0 listens to qualified primary activity and to primary interrupts. Timer 1 listens to a selectable subset of peripheral activity.

Activity arrives as one-cycle pulses on an 8-bit vector with these bit positions:

| Bit | Activity |
|-----|----------|
| 7 | keyboard |
| 6 | serial |
| 5 | parallel |
| 4 | video |
| 3 | disk |
| 2 | reserved |
| 1 | primary interrupt |
| 0 | bus-master/DMA |

Top module: `pm_idle_timers`

Register map (word addresses). Unlisted bits read 0.

| Address | Contents |
|---------|----------|
| 0 | control: [1:0] time base of timer 0, [3:2] time base of timer 1, [4] start/run timer 0, [5] start/run timer 1, [6] auto-reload timer 0, [7] auto-reload timer 1, [8] activity reload enable for timer 0, [9] primary-interrupt reload enable for timer 0 |
| 1 | initial count of timer 0 |
| 2 | initial count of timer 1 |
| 3 | timeout flags: bit 0 timer 0, bit 1 timer 1; write 1 to clear |
| 4 | interrupt enables, same bit order as address 3 |
| 5 | activity mask for timer 0 |
| 6 | peripheral select for timer 1 |
| 7 | current count of timer 0 (read only) |
| 8 | current count of timer 1 (read only) |

## Requirements
- R1: After reset every register, both current counts and smi_req are 0.
- R2: A write to address 0 with a timer's start bit at 1 loads that timer's initial count on the write edge. The timer is then running and decrements by one per time-base tick. The tick that takes the count from 1 to 0 sets the timer's bit in address 3.
- R3: smi_req is 1 exactly when some bit of address 3 is set together with the same bit of address 4.
- R4: Writing 1 to a bit of address 3 clears it, and writing 0 leaves it unchanged. If a timeout occurs on the same edge as a clear of the same bit, the bit ends set.
- R5: With auto-reload set, the tick that would take the count from 1 to 0 loads the initial count instead and still sets the timeout bit.
- R6: A write to address 0 with the start bit at 0 stops the timer, and its count then stays frozen. Activity pulses that arrive while a timer is stopped leave its count unchanged.
- R7: While timer 0 runs and control bit 8 is set, a pulse on activity bit 7, 6, 5, 4, 3 or 0 whose bit is also set in address 5 reloads timer 0's initial count on that edge. Activity bit 2 never reloads.
- R8: Activity bit 1 reloads a running timer 0 only when control bit 9 is set, whatever control bit 8 and address 5 hold.
- R9: While timer 1 runs, a pulse on activity bit 7, 6, 4 or 3 whose bit is set in address 6 reloads timer 1's initial count. Bits 5, 2, 1 and 0 never reload timer 1.
- R10: Time-base codes 0, 1, 2 and 3 give one tick every 1, 16, 256 and 4096 clocks, taken from one free-running prescaler.
- R11: A count that has reached 0 without auto-reload stays at 0 and sets no further timeout. An initial count of 0 never times out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | AW | write word address |
| wr_data | input | DW | write data |
| rd_addr | input | AW | read word address |
| rd_data | output | DW | read data, combinational from rd_addr |
| act_evt | input | 8 | one-cycle activity pulses, bit positions as listed above |
| smi_req | output | 1 | system-management interrupt request, level |

## Verification
The hardest case to reach is a timeout that lands on the very edge where software clears the same flag. The bench gets there by counting edges from the start write with the single-clock time base. It issues the clear write so that it lands on the edge where the count goes from 1 to 0.

Reload qualification is checked by pulsing one activity bit at a time against a running count. The bench then reads back whether the count returned to its initial value or just stepped down by one.

The slower time bases depend on the prescaler's phase, which cannot be seen from the ports. They are checked through how far the count falls over a window of exactly one or two tick periods.

// File: rtl/pm_timer_pkg.sv
package pm_timer_pkg;
    localparam int NRATE = 4;
    localparam int TBW   = 2;
    localparam int EVW   = 8;
    localparam int NTMR  = 2;

    // word addresses
    localparam int A_CTRL  = 0;
    localparam int A_INIT0 = 1;
    localparam int A_INIT1 = 2;
    localparam int A_STS   = 3;
    localparam int A_SMIEN = 4;
    localparam int A_PMASK = 5;
    localparam int A_PSEL  = 6;
    localparam int A_CNT0  = 7;
    localparam int A_CNT1  = 8;

    // control word bit positions
    localparam int C_TB0   = 0;
    localparam int C_START = 4;
    localparam int C_AUTO  = 6;
    localparam int C_PRLD  = 8;
    localparam int C_PIRQ  = 9;
    localparam int CTRL_W  = 10;

    // activity qualification
    localparam logic [EVW-1:0] PRI_MASK = 8'hF9;
    localparam logic [EVW-1:0] PER_MASK = 8'hD8;
    localparam int             EV_PIRQ  = 1;
endpackage

// File: rtl/pm_prescaler.sv
module pm_prescaler
    import pm_timer_pkg::*;
#(
    parameter int STEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [NRATE-1:0] tick_o
);
    localparam int PW = STEP * (NRATE - 1);

    typedef struct packed {
        logic [PW-1:0] pre;
    } pre_s;

    pre_s s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.pre = s_q.pre + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_o[0] = 1'b1;
    for (genvar i = 1; i < NRATE; i++) begin : g_rate
        assign tick_o[i] = &s_q.pre[STEP*i-1:0];
    end

    // R10: the divide-by-16 tick is never high on two edges in a row
    p_tick_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o[1] |=> !tick_o[1]);
endmodule

// File: rtl/pm_countdown.sv
module pm_countdown #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          load_i,
    input  logic          reload_i,
    input  logic          tick_i,
    input  logic          auto_i,
    input  logic [CW-1:0] init_i,
    output logic [CW-1:0] cnt_o,
    output logic          expire_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cd_s;

    cd_s s_d, s_q;

    always_comb begin
        s_d      = s_q;
        expire_o = 1'b0;
        if (load_i) begin
            s_d.cnt = init_i;
        end else if (run_i && reload_i) begin
            s_d.cnt = init_i;
        end else if (run_i && tick_i && s_q.cnt != '0) begin
            if (s_q.cnt == CW'(1)) begin
                expire_o = 1'b1;
                s_d.cnt  = auto_i ? init_i : '0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;

    // R6: a stopped timer with no start write holds its count
    p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(s_q.cnt));

    // R5 and R11: after a timeout the count is the initial value or zero
    p_after_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> (s_q.cnt == ($past(auto_i) ? $past(init_i) : '0)));

    // R7 and R9: a qualified reload restores the initial count
    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && reload_i && !load_i) |=> (s_q.cnt == $past(init_i)));
endmodule

// File: rtl/pm_regs.sv
module pm_regs
    import pm_timer_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic [AW-1:0]            rd_addr,
    output logic [DW-1:0]            rd_data,
    input  logic [NTMR-1:0]          expire_i,
    input  logic [NTMR-1:0][CW-1:0]  cnt_i,
    output logic [NTMR-1:0]          run_o,
    output logic [NTMR-1:0]          auto_o,
    output logic [NTMR-1:0]          load_o,
    output logic [NTMR-1:0][TBW-1:0] tb_o,
    output logic [NTMR-1:0][CW-1:0]  init_o,
    output logic                     prld_o,
    output logic                     pirq_o,
    output logic [EVW-1:0]           pmask_o,
    output logic [EVW-1:0]           psel_o,
    output logic                     smi_o
);
    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [CW-1:0]     init0;
        logic [CW-1:0]     init1;
        logic [NTMR-1:0]   sts;
        logic [NTMR-1:0]   smien;
        logic [EVW-1:0]    pmask;
        logic [EVW-1:0]    psel;
    } reg_s;

    reg_s            s_d, s_q;
    logic [NTMR-1:0] clr;

    always_comb begin
        s_d    = s_q;
        load_o = '0;
        clr    = '0;
        if (wr_en) begin
            case (wr_addr)
                AW'(A_CTRL): begin
                    s_d.ctrl = wr_data[CTRL_W-1:0];
                    load_o   = wr_data[C_START +: NTMR];
                end
                AW'(A_INIT0): s_d.init0 = wr_data[CW-1:0];
                AW'(A_INIT1): s_d.init1 = wr_data[CW-1:0];
                AW'(A_STS):   clr       = wr_data[NTMR-1:0];
                AW'(A_SMIEN): s_d.smien = wr_data[NTMR-1:0];
                AW'(A_PMASK): s_d.pmask = wr_data[EVW-1:0];
                AW'(A_PSEL):  s_d.psel  = wr_data[EVW-1:0];
                default: ;
            endcase
        end
        // a timeout on the clearing edge keeps the flag set
        s_d.sts = (s_q.sts & ~clr) | expire_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (rd_addr)
            AW'(A_CTRL):  rd_data = DW'(s_q.ctrl);
            AW'(A_INIT0): rd_data = DW'(s_q.init0);
            AW'(A_INIT1): rd_data = DW'(s_q.init1);
            AW'(A_STS):   rd_data = DW'(s_q.sts);
            AW'(A_SMIEN): rd_data = DW'(s_q.smien);
            AW'(A_PMASK): rd_data = DW'(s_q.pmask);
            AW'(A_PSEL):  rd_data = DW'(s_q.psel);
            AW'(A_CNT0):  rd_data = DW'(cnt_i[0]);
            AW'(A_CNT1):  rd_data = DW'(cnt_i[1]);
            default:      rd_data = '0;
        endcase
    end

    for (genvar t = 0; t < NTMR; t++) begin : g_fields
        assign run_o[t]  = s_q.ctrl[C_START + t];
        assign auto_o[t] = s_q.ctrl[C_AUTO + t];
        assign tb_o[t]   = s_q.ctrl[C_TB0 + TBW*t +: TBW];
    end
    assign init_o[0] = s_q.init0;
    assign init_o[1] = s_q.init1;
    assign prld_o    = s_q.ctrl[C_PRLD];
    assign pirq_o    = s_q.ctrl[C_PIRQ];
    assign pmask_o   = s_q.pmask;
    assign psel_o    = s_q.psel;
    assign smi_o     = |(s_q.sts & s_q.smien);

    // R4: a timeout always leaves its flag set, even against a clear
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|expire_i) |=> ((s_q.sts & $past(expire_i)) == $past(expire_i)));

    // R4: a clear with no competing timeout drops the flag
    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(A_STS) && wr_data[0] && !expire_i[0])
        |=> !s_q.sts[0]);
endmodule

// File: rtl/pm_idle_timers.sv
module pm_idle_timers
    import pm_timer_pkg::*;
#(
    parameter int AW   = 4,
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int STEP = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [DW-1:0]  rd_data,
    input  logic [EVW-1:0] act_evt,
    output logic           smi_req
);
    logic [NRATE-1:0]          tick_v;
    logic [NTMR-1:0]           run, auto_rl, load, reload, tick, expire;
    logic [NTMR-1:0][TBW-1:0]  tb;
    logic [NTMR-1:0][CW-1:0]   init, cnt;
    logic                      prld, pirq;
    logic [EVW-1:0]            pmask, psel;

    pm_prescaler #(.STEP(STEP)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick_v)
    );

    pm_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .expire_i (expire),
        .cnt_i    (cnt),
        .run_o    (run),
        .auto_o   (auto_rl),
        .load_o   (load),
        .tb_o     (tb),
        .init_o   (init),
        .prld_o   (prld),
        .pirq_o   (pirq),
        .pmask_o  (pmask),
        .psel_o   (psel),
        .smi_o    (smi_req)
    );

    always_comb begin
        reload[0] = (prld && |(act_evt & pmask & PRI_MASK))
                  || (pirq && act_evt[EV_PIRQ]);
        reload[1] = |(act_evt & psel & PER_MASK);
    end

    for (genvar t = 0; t < NTMR; t++) begin : g_tmr
        assign tick[t] = tick_v[tb[t]];
        pm_countdown #(.CW(CW)) u_cd (
            .clk      (clk),
            .rst_n    (rst_n),
            .run_i    (run[t]),
            .load_i   (load[t]),
            .reload_i (reload[t]),
            .tick_i   (tick[t]),
            .auto_i   (auto_rl[t]),
            .init_i   (init[t]),
            .cnt_o    (cnt[t]),
            .expire_o (expire[t])
        );
    end

    // R8: the primary-interrupt line cannot reload timer 0 on its own without its enable
    p_pirq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run[0] && !load[0] && !pirq && act_evt == 8'h02 && !tick[0])
        |=> $stable(cnt[0]));
endmodule

// File: tb/pm_idle_timers_tb_top.sv
`timescale 1ns/1ps
module pm_idle_timers_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [7:0]  act_evt = '0;
    logic        smi_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pm_idle_timers dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .act_evt (act_evt),
        .smi_req (smi_req)
    );

    // vector table: initial count, edges to wait, expected count, expected flag
    localparam int NV = 8;
    localparam logic [15:0] V_INIT [NV] = '{16'd5, 16'd5, 16'd1, 16'd8, 16'd0, 16'd3, 16'd200, 16'd4};
    localparam int          V_WAIT [NV] = '{2, 5, 1, 3, 4, 10, 150, 4};
    localparam logic [15:0] V_CNT  [NV] = '{16'd3, 16'd0, 16'd0, 16'd5, 16'd0, 16'd0, 16'd50, 16'd0};
    localparam logic [15:0] V_STS  [NV] = '{16'd0, 16'd1, 16'd1, 16'd0, 16'd0, 16'd1, 16'd0, 16'd1};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic [7:0] e);
        act_evt = e;
        @(negedge clk);
        act_evt = '0;
    endtask

    initial begin
        logic [15:0] v, a, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'd0, v); chk("R1 ctrl", v, 0);
        rd(4'd3, v); chk("R1 status", v, 0);
        rd(4'd7, v); chk("R1 count0", v, 0);
        rd(4'd8, v); chk("R1 count1", v, 0);
        chk("R1 smi_req", smi_req, 0);

        // R2 and R11 vector walk, timer 0 at one tick per clock
        for (int i = 0; i < NV; i++) begin
            wr(4'd0, 16'h0000);
            wr(4'd3, 16'h0003);
            wr(4'd1, V_INIT[i]);
            wr(4'd0, 16'h0010);
            idle(V_WAIT[i]);
            rd(4'd7, v); chk((V_INIT[i] == 0 || V_WAIT[i] > V_INIT[i]) ? "R11 count" : "R2 count", v, V_CNT[i]);
            rd(4'd3, v); chk((V_INIT[i] == 0 || V_WAIT[i] > V_INIT[i]) ? "R11 flag" : "R2 flag", v & 16'h1, V_STS[i]);
        end

        // R3 interrupt request follows flag and enable
        wr(4'd4, 16'h0001); chk("R3 smi on", smi_req, 1);
        wr(4'd4, 16'h0002); chk("R3 smi other enable", smi_req, 0);
        wr(4'd4, 16'h0000);

        // R4 clear, then timeout coinciding with clear
        wr(4'd3, 16'h0001); rd(4'd3, v); chk("R4 cleared", v, 0);
        wr(4'd0, 16'h0000);
        wr(4'd1, 16'd2);
        wr(4'd0, 16'h0010);
        idle(1);
        wr(4'd3, 16'h0001);
        rd(4'd3, v); chk("R4 set wins", v & 16'h1, 1);
        chk("R3 smi disabled", smi_req, 0);
        wr(4'd3, 16'h0001); rd(4'd3, v); chk("R4 cleared again", v, 0);

        // R5 auto-reload
        wr(4'd0, 16'h0000);
        wr(4'd1, 16'd3);
        wr(4'd0, 16'h0050);
        idle(3);
        rd(4'd7, v); chk("R5 reloaded", v, 3);
        rd(4'd3, v); chk("R5 flag", v & 16'h1, 1);
        idle(1);
        rd(4'd7, v); chk("R5 keeps running", v, 2);

        // R6 freeze and ignored activity while stopped
        wr(4'd0, 16'h0000);
        wr(4'd5, 16'h00FF);
        wr(4'd1, 16'd10);
        wr(4'd0, 16'h0110);
        idle(3);
        rd(4'd7, v); chk("R6 running", v, 7);
        wr(4'd0, 16'h0100);
        idle(5);
        rd(4'd7, v); chk("R6 frozen", v, 6);
        pulse(8'h80);
        rd(4'd7, v); chk("R6 pulse ignored", v, 6);

        // R7 primary activity reload
        wr(4'd0, 16'h0110);
        idle(4);
        rd(4'd7, v); chk("R7 before", v, 6);
        pulse(8'h80); rd(4'd7, v); chk("R7 keyboard reload", v, 10);
        pulse(8'h04); rd(4'd7, v); chk("R7 reserved ignored", v, 9);
        pulse(8'h01); rd(4'd7, v); chk("R7 dma reload", v, 10);
        wr(4'd5, 16'h0001);
        pulse(8'h80); rd(4'd7, v); chk("R7 masked", v, 8);

        // R8 primary interrupt reload gate
        wr(4'd5, 16'h00FF);
        pulse(8'h02); rd(4'd7, v); chk("R8 no enable", v, 6);
        wr(4'd0, 16'h0210);
        idle(2);
        pulse(8'h02); rd(4'd7, v); chk("R8 enabled reload", v, 10);

        // R9 peripheral select for timer 1
        wr(4'd0, 16'h0000);
        wr(4'd6, 16'h00FF);
        wr(4'd2, 16'd10);
        wr(4'd0, 16'h0020);
        idle(3);
        rd(4'd8, v); chk("R9 running", v, 7);
        pulse(8'h20); rd(4'd8, v); chk("R9 parallel ignored", v, 6);
        pulse(8'h40); rd(4'd8, v); chk("R9 serial reload", v, 10);
        wr(4'd6, 16'h0008);
        pulse(8'h40); rd(4'd8, v); chk("R9 deselected", v, 8);
        pulse(8'h08); rd(4'd8, v); chk("R9 disk reload", v, 10);

        // R10 time bases
        wr(4'd0, 16'h0000);
        wr(4'd1, 16'd1000);
        wr(4'd0, 16'h0011);
        rd(4'd7, a); idle(16); rd(4'd7, b); chk("R10 div16 one", a - b, 1);
        rd(4'd7, a); idle(32); rd(4'd7, b); chk("R10 div16 two", a - b, 2);
        wr(4'd0, 16'h0012);
        rd(4'd7, a); idle(256); rd(4'd7, b); chk("R10 div256", a - b, 1);
        wr(4'd0, 16'h0013);
        rd(4'd7, a); idle(4096); rd(4'd7, b); chk("R10 div4096 one", a - b, 1);
        rd(4'd7, a); idle(8192); rd(4'd7, b); chk("R10 div4096 two", a - b, 2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule